// File: doc/BRIEF.md
# MSI Snooping Coherence Controller for One Cache Line

This block keeps one cache line coherent in a write-back, write-invalidate system in which every cache watches a shared bus. The line is always Invalid, Shared or Modified. Local processor reads and writes that can be served from the current state complete at once. Any other access becomes a bus request, and the processor is held until the arbiter grants it. Each cycle the controller also looks at the transaction another cache has placed on the bus. It drops or demotes its own copy when that transaction needs it to, and drives a flush when its dirty data must go back to memory.

There is no exclusive-clean state. A line that is read and then written costs two bus transactions even when no other cache holds it. The address compare, data array, arbiter and memory sit outside the block. The controller only needs a match bit for the processor request and a match bit for the snooped transaction.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid. `line_state` encodes Invalid 2'b00, Shared 2'b01 and Modified 2'b10. `cpu_ready`, `bus_req_valid` and `flush` are low.
- R2: A matching read while Shared or Modified, or a matching write while Modified, raises `cpu_ready` in the same cycle. It starts no bus request and leaves the state unchanged.
- R3: Any other read starts a bus request with code 2'b01 from the next cycle. `cpu_ready` stays low until `bus_gnt`. In the grant cycle `cpu_ready` is high, and the line is Shared after that edge.
- R4: Any write that is not a hit requests code 2'b10. This covers a write while Invalid or Shared, or a write that does not match. In the grant cycle `cpu_ready` is high, and the line is Modified after that edge.
- R5: A miss that does not match while the line is Modified first requests a write-back with code 2'b11. On that grant the line becomes Invalid, and the fill request of R3 or R4 follows from the next cycle.
- R6: A snooped read (`snoop_cmd` 2'b01) that matches and was not issued by this controller drives `flush` in the same cycle while the line is Modified. The line is then Shared.
- R7: A snooped read-exclusive (2'b10) that matches and is foreign invalidates the line. It also drives `flush` in that cycle if the line was Modified.
- R8: A snoop with `snoop_match` low, with `snoop_self` high, or with code 2'b00 or 2'b11 changes no state and drives no flush.
- R9: When an active snoop (R6 or R7 conditions) and a new processor request arrive in the same idle cycle, the snoop is applied first. `cpu_ready` stays low and the request is evaluated again in the next cycle.
- R10: When a grant and an active snoop share a cycle, the grant decides the final state. `flush` is still driven if the line was Modified before that edge.
- R11: If a snoop flushes the line while a write-back is waiting, the write-back is dropped. The fill request is made from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present, held until `cpu_ready` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_match | input | 1 | Request address equals the held line's address |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 01 read, 10 read-exclusive, 11 write-back |
| bus_gnt | input | 1 | Arbiter grant for the pending request |
| snoop_cmd | input | 2 | Snooped code: 00 none, 01 read, 10 read-exclusive, 11 write-back |
| snoop_match | input | 1 | Snooped address equals the held line's address |
| snoop_self | input | 1 | Snooped transaction was issued by this controller |
| flush | output | 1 | Dirty data must be supplied this cycle |
| line_state | output | 2 | Current coherence state |

## Verification
Two functions collide in this block: the response to a foreign snoop and the progress of the local processor access. Directed sequences force a snoop into the same cycle as a new hit request, as a write-back grant, and as a waiting write-back. Random traffic then overlaps snoops with requests and grants at high density. A bench model built from the requirements predicts the same-cycle `flush`, `cpu_ready` and bus request values, and the state after each edge. From these it judges that the snoop wins over an idle request, that the grant wins over the snoop, and that a snoop flush cancels a write-back.

// File: rtl/msi_pkg.sv
package msi_pkg;
    localparam int CMD_W = 2;

    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_SHR = 2'b01,
        LN_MOD = 2'b10
    } line_st_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_WBACK = 2'b01,
        PH_FILL  = 2'b10
    } phase_t;

    localparam logic [CMD_W-1:0] CMD_NONE = 2'b00;
    localparam logic [CMD_W-1:0] CMD_RD   = 2'b01;
    localparam logic [CMD_W-1:0] CMD_RDX  = 2'b10;
    localparam logic [CMD_W-1:0] CMD_WB   = 2'b11;

    typedef struct packed {
        line_st_t st;
        phase_t   ph;
        logic     wr;
    } ctl_t;
endpackage

// File: rtl/msi_snoop_resp.sv
module msi_snoop_resp
    import msi_pkg::*;
(
    input  line_st_t         st_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             match_i,
    input  logic             self_i,
    output line_st_t         st_nxt_o,
    output logic             flush_o,
    output logic             active_o
);
    always_comb begin
        active_o = match_i && !self_i && (cmd_i == CMD_RD || cmd_i == CMD_RDX);
        flush_o  = active_o && (st_i == LN_MOD);
        st_nxt_o = st_i;
        if (active_o) begin
            if (cmd_i == CMD_RDX)
                st_nxt_o = LN_INV;
            else if (st_i == LN_MOD)
                st_nxt_o = LN_SHR;
        end
    end
endmodule

// File: rtl/msi_req_eval.sv
module msi_req_eval
    import msi_pkg::*;
(
    input  line_st_t st_i,
    input  logic     valid_i,
    input  logic     write_i,
    input  logic     match_i,
    output logic     hit_o,
    output logic     needs_wb_o
);
    always_comb begin
        hit_o = valid_i && match_i &&
                (write_i ? (st_i == LN_MOD) : (st_i != LN_INV));
        needs_wb_o = valid_i && !match_i && (st_i == LN_MOD);
    end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req_valid,
    input  logic             cpu_req_write,
    input  logic             cpu_req_match,
    output logic             cpu_ready,
    output logic             bus_req_valid,
    output logic [CMD_W-1:0] bus_req_cmd,
    input  logic             bus_gnt,
    input  logic [CMD_W-1:0] snoop_cmd,
    input  logic             snoop_match,
    input  logic             snoop_self,
    output logic             flush,
    output logic [1:0]       line_state
);
    ctl_t     ctl_d, ctl_q;
    line_st_t snp_st_nxt;
    logic     snp_flush, snp_active;
    logic     req_hit, req_wb;

    msi_snoop_resp u_snoop (
        .st_i     (ctl_q.st),
        .cmd_i    (snoop_cmd),
        .match_i  (snoop_match),
        .self_i   (snoop_self),
        .st_nxt_o (snp_st_nxt),
        .flush_o  (snp_flush),
        .active_o (snp_active)
    );

    msi_req_eval u_req (
        .st_i       (ctl_q.st),
        .valid_i    (cpu_req_valid),
        .write_i    (cpu_req_write),
        .match_i    (cpu_req_match),
        .hit_o      (req_hit),
        .needs_wb_o (req_wb)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.st  = snp_st_nxt;
        cpu_ready = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (cpu_req_valid && !snp_active) begin
                    if (req_hit) begin
                        cpu_ready = 1'b1;
                    end else begin
                        ctl_d.ph = req_wb ? PH_WBACK : PH_FILL;
                        ctl_d.wr = cpu_req_write;
                    end
                end
            end
            PH_WBACK: begin
                if (bus_gnt) begin
                    ctl_d.st = LN_INV;
                    ctl_d.ph = PH_FILL;
                end else if (snp_active && snp_st_nxt != LN_MOD) begin
                    ctl_d.ph = PH_FILL;
                end
            end
            PH_FILL: begin
                if (bus_gnt) begin
                    ctl_d.st  = ctl_q.wr ? LN_MOD : LN_SHR;
                    ctl_d.ph  = PH_IDLE;
                    cpu_ready = 1'b1;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st <= LN_INV;
            ctl_q.ph <= PH_IDLE;
            ctl_q.wr <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_req_valid = (ctl_q.ph != PH_IDLE);
    assign bus_req_cmd   = (ctl_q.ph == PH_WBACK) ? CMD_WB :
                           (ctl_q.ph == PH_FILL) ? (ctl_q.wr ? CMD_RDX : CMD_RD) : CMD_NONE;
    assign flush         = snp_flush;
    assign line_state    = ctl_q.st;

    AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_IDLE && cpu_ready) |=> !bus_req_valid); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_gnt) |=> bus_req_valid); // R3
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_WBACK && bus_gnt) |=> (line_state == LN_INV && bus_req_cmd != CMD_WB)); // R5
    AST_FLUSH_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (line_state == LN_MOD)); // R6
    AST_RDX_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_IDLE && snoop_cmd == CMD_RDX && snoop_match && !snoop_self)
        |=> (line_state == LN_INV)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_IDLE && !(snoop_match && !snoop_self &&
         (snoop_cmd == CMD_RD || snoop_cmd == CMD_RDX))) |=> $stable(line_state)); // R8
    AST_GRANT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_FILL && bus_gnt && bus_req_cmd == CMD_RDX) |=> (line_state == LN_MOD)); // R10
endmodule

// File: tb/msi_line_ctrl_tb_top.sv
module msi_line_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rv = 1'b0, rw = 1'b0, rm = 1'b0, gnt = 1'b0;
    logic [1:0] sc = 2'b00;
    logic       sm = 1'b0, ss = 1'b0;
    logic       ready, breq, flush;
    logic [1:0] bcmd, lstate;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // model
    logic [1:0] m_st = 2'b00;
    int         m_ph = 0;
    logic       m_wr = 1'b0;
    string      st_tag = "R1";
    bit         pend = 0;

    always #10 clk = ~clk;

    msi_line_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(rv), .cpu_req_write(rw), .cpu_req_match(rm),
        .cpu_ready(ready), .bus_req_valid(breq), .bus_req_cmd(bcmd), .bus_gnt(gnt),
        .snoop_cmd(sc), .snoop_match(sm), .snoop_self(ss),
        .flush(flush), .line_state(lstate)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit snp_eff(input logic [1:0] c, input logic m, input logic s);
        return m && !s && (c == 2'b01 || c == 2'b10);
    endfunction

    function automatic logic [1:0] snp_next(input logic [1:0] st, input logic [1:0] c, input bit eff);
        if (!eff) return st;
        if (c == 2'b10) return 2'b00;
        if (st == 2'b10) return 2'b01;
        return st;
    endfunction

    task automatic step(input logic i_rv, input logic i_rw, input logic i_rm,
                        input logic i_gnt, input logic [1:0] i_sc,
                        input logic i_sm, input logic i_ss);
        bit eff, hit, e_ready, e_flush;
        logic [1:0] e_cmd, ns;
        @(negedge clk);
        chk(st_tag, {2'b00, lstate}, {2'b00, m_st});
        rv = i_rv; rw = i_rw; rm = i_rm; gnt = i_gnt;
        sc = i_sc; sm = i_sm; ss = i_ss;
        #1;
        eff     = snp_eff(sc, sm, ss);
        hit     = rv && rm && (rw ? (m_st == 2'b10) : (m_st != 2'b00));
        e_flush = eff && (m_st == 2'b10);
        e_ready = (m_ph == 0 && rv && hit && !eff) || (m_ph == 2 && gnt);
        e_cmd   = (m_ph == 1) ? 2'b11 : (m_ph == 2) ? (m_wr ? 2'b10 : 2'b01) : 2'b00;
        chk(eff ? ((sc == 2'b01) ? "R6" : "R7") : "R8", {3'b0, flush}, {3'b0, e_flush});
        chk((m_ph == 0) ? ((eff && rv) ? "R9" : "R2") : "R3", {3'b0, ready}, {3'b0, e_ready});
        chk((m_ph == 1) ? "R5" : (m_wr ? "R4" : "R3"), {1'b0, breq, bcmd},
            {1'b0, (m_ph != 0) ? 1'b1 : 1'b0, e_cmd});
        // model update
        ns = snp_next(m_st, sc, eff);
        st_tag = eff ? ((sc == 2'b01) ? "R6" : "R7") : "R8";
        if (m_ph == 0) begin
            if (rv && !eff) begin
                if (hit) st_tag = "R2";
                else begin
                    m_ph = (!rm && m_st == 2'b10) ? 1 : 2;
                    m_wr = rw;
                end
            end
        end else if (m_ph == 1) begin
            if (gnt) begin
                ns = 2'b00; m_ph = 2; st_tag = eff ? "R10" : "R5";
            end else if (eff) begin
                m_ph = 2; st_tag = "R11";
            end
        end else if (gnt) begin
            ns = m_wr ? 2'b10 : 2'b01; m_ph = 0;
            st_tag = eff ? "R10" : (m_wr ? "R4" : "R3");
        end
        m_st = ns;
        pend = rv && !e_ready;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", {2'b00, lstate}, 4'h0);
        chk("R1", {1'b0, ready, breq, flush}, 4'h0);
        // directed
        step(1,0,1,0,2'b00,0,0);   // R3 read miss in I
        step(1,0,1,1,2'b00,0,0);   // grant -> S
        step(1,0,1,0,2'b00,0,0);   // R2 read hit
        step(1,1,1,0,2'b00,0,0);   // R4 upgrade
        step(1,1,1,0,2'b00,0,0);
        step(1,1,1,1,2'b00,0,0);   // -> M
        step(0,0,0,0,2'b01,1,0);   // R6 snoop read in M
        step(1,1,1,0,2'b00,0,0);
        step(1,1,1,1,2'b00,0,0);   // M
        step(0,0,0,0,2'b10,1,1);   // R8 self
        step(0,0,0,0,2'b10,0,0);   // R8 no match
        step(0,0,0,0,2'b11,1,0);   // R8 write-back code
        step(1,1,1,0,2'b10,1,0);   // R9 hit with snoop RdX
        step(1,1,1,0,2'b00,0,0);   // re-evaluated, miss
        step(1,1,1,1,2'b00,0,0);   // M
        step(1,0,0,0,2'b00,0,0);   // R5 replacement
        step(1,0,0,1,2'b00,0,0);   // wb grant -> I
        step(1,0,0,1,2'b01,1,0);   // fill grant -> S
        step(1,1,1,0,2'b00,0,0);
        step(1,1,1,1,2'b00,0,0);   // M
        step(1,0,0,0,2'b00,0,0);   // wb pending
        step(1,0,0,1,2'b01,1,0);   // R10 grant + snoop, flush
        step(1,0,0,1,2'b00,0,0);   // S
        step(1,1,1,0,2'b00,0,0);
        step(1,1,1,1,2'b00,0,0);   // M
        step(1,1,0,0,2'b00,0,0);   // wb pending
        step(1,1,0,0,2'b10,1,0);   // R11 snoop flushes, wb dropped
        step(1,1,0,0,2'b00,0,0);   // fill request RdX
        step(1,1,0,1,2'b00,0,0);   // M
        // random
        for (int i = 0; i < 4000; i++) begin
            logic a_rv, a_rw, a_rm, a_g, a_sm, a_ss;
            logic [1:0] a_sc;
            if (pend) begin a_rv = rv; a_rw = rw; a_rm = rm; end
            else begin
                a_rv = ($urandom % 3) == 0;
                a_rw = $urandom % 2;
                a_rm = ($urandom % 4) != 0;
            end
            a_g  = (m_ph != 0) && (($urandom % 3) == 0);
            a_sc = (($urandom % 5) < 2) ? 2'b00 : 2'($urandom % 4);
            a_sm = ($urandom % 4) != 0;
            a_ss = ($urandom % 7) == 0;
            step(a_rv, a_rw, a_rm, a_g, a_sc, a_sm, a_ss);
        end
        @(negedge clk);
        chk(st_tag, {2'b00, lstate}, {2'b00, m_st});
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule